// File: doc/BRIEF.md
# Gate Interval Comparator

This block is the measuring half of a timer channel when the channel is set to compare a gate signal against a programmed time-out. It owns a down counter loaded from the channel's latch value. It watches an active-low gate input and decides when the counter is initialized and when it is allowed to count. When the measured gate interval falls on the selected side of the time-out, it issues a one-cycle interrupt-set pulse.

There are two measurements. In period mode the interval runs from one falling gate edge to the next. In width mode the interval is the time the gate stays low. A third mode bit selects the sense of the test. With the bit clear, the pulse fires when the closing edge comes before time-out. With the bit set, it fires when the closing edge comes after time-out. The interrupt flag itself lives outside the block and is fed back as `irq_pend_i`. A pending flag freezes the measurement until software clears it.

Top module: `gate_interval_cmp`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it rises, `cnt_en_o`, `cnt_init_o`, `irq_set_o`, `timed_out_o` are 0 and `count_o` is 0.
- R2: A cycle with `cnt_init_o` or `clr_i` loads `count_o` with `latch_val_i` and clears `timed_out_o`. Each later cycle with `cnt_en_o` and `tick_i` decrements a nonzero count. The count then holds at zero without wrapping. `timed_out_o` sets on the first enabled tick that finds the count at zero, so it is set after N+1 enabled ticks for a latch value N.
- R3: In width mode, a falling gate edge with no pending interrupt and no `clr_i` raises `cnt_init_o` in that cycle and sets `cnt_en_o` from the next cycle.
- R4: In width mode with the late bit clear, a rising gate edge while enabled raises `irq_set_o` when the gate was low for L enabled ticks with L <= N, and raises nothing when L > N.
- R5: In width mode with the late bit set, a rising gate edge while enabled raises `irq_set_o` only when L >= N+1.
- R6: In width mode, `cnt_en_o` is 0 on the cycle after any cycle in which the gate is high.
- R7: In period mode with the late bit clear, a falling edge while not enabled initializes and enables. A falling edge after K enabled ticks with K <= N raises `irq_set_o` without initializing. With K > N, it initializes with no pulse.
- R8: In period mode with the late bit set, every falling edge with no pending interrupt initializes. The edge raises `irq_set_o` when K >= N+1 enabled ticks have passed since the previous initialization.
- R9: With `irq_pend_i` high, a gate edge neither initializes nor enables nor raises `irq_set_o`, and `cnt_en_o` is 0 on the next cycle.
- R10: A cycle with `latch_wr_i` high leaves `cnt_en_o` 0 on the next cycle, even if a falling edge arrives in it. A closing edge that comes while not enabled raises no pulse.
- R11: A cycle with `clr_i` high raises neither `cnt_init_o` nor `irq_set_o`. On the next cycle `cnt_en_o` and `timed_out_o` are 0 and the count equals the latch value.
- R12: Mode encoding: `mode_i[0]`=1 selects compare operation, `mode_i[1]`=1 selects width (0 period), `mode_i[2]`=1 selects the after-time-out test. With `mode_i[0]`=0 the block never initializes, enables or raises a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | {late, width, compare} mode bits |
| gate_ni | input | 1 | Gate, active low, synchronous to clk_i |
| tick_i | input | 1 | Count tick qualifier |
| latch_val_i | input | CNT_W | Time-out value N |
| latch_wr_i | input | 1 | Latch write pulse |
| clr_i | input | 1 | Synchronous channel preset |
| irq_pend_i | input | 1 | Current interrupt flag of the channel |
| cnt_en_o | output | 1 | Counter-enable state |
| cnt_init_o | output | 1 | Counter-initialize pulse |
| irq_set_o | output | 1 | Interrupt-set pulse |
| timed_out_o | output | 1 | Time-out reached in current window |
| count_o | output | CNT_W | Current counter value |

## Verification
The hardest case is a closing gate edge that lands exactly on the boundary between N and N+1 enabled ticks. One tick decides between a pulse and none, and between holding the count and initializing it. The bench holds the tick high so that elapsed cycles equal ticks. It then sweeps the gate interval across the whole range around every latch value, in both modes and for both test senses. The expected pulse and initialization are computed arithmetically from the interval length.

// File: rtl/gate_cmp_pkg.sv
package gate_cmp_pkg;

  typedef struct packed {
    logic late;    // fire when closing edge follows time-out
    logic width;   // measure low time instead of period
    logic active;  // compare operation selected
  } cmp_cfg_t;

  function automatic cmp_cfg_t decode_mode(input logic [2:0] m);
    cmp_cfg_t c;
    c.late   = m[2];
    c.width  = m[1];
    c.active = m[0];
    return c;
  endfunction

endpackage

// File: rtl/gate_edge_det.sv
module gate_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_ni,
  output logic fall_o,
  output logic rise_o
);

  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b1;
    else         gate_q <= gate_ni;
  end

  assign fall_o = gate_q & ~gate_ni;
  assign rise_o = ~gate_q & gate_ni;

endmodule

// File: rtl/gate_down_cnt.sv
module gate_down_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             en_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             timed_out_o
);

  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] count_q;
  logic             seen_q;
  logic             step;
  logic             at_zero;

  assign step    = en_i & tick_i;
  assign at_zero = (count_q == ZERO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= ZERO;
      seen_q  <= 1'b0;
    end else if (load_i) begin
      count_q <= load_val_i;
      seen_q  <= 1'b0;
    end else if (step) begin
      if (at_zero) seen_q  <= 1'b1;
      else         count_q <= count_q - 1'b1;
    end
  end

  assign count_o     = count_q;
  assign timed_out_o = seen_q;

  assert_hold_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_zero && !load_i) |=> (count_q == ZERO));

  assert_step_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !at_zero && !load_i) |=> (count_q == $past(count_q) - 1'b1));

  assert_seen_at_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seen_q) |-> $past(at_zero));

endmodule

// File: rtl/gate_cmp_ctrl.sv
module gate_cmp_ctrl
  import gate_cmp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cmp_cfg_t cfg_i,
  input  logic     gate_ni,
  input  logic     fall_i,
  input  logic     rise_i,
  input  logic     latch_wr_i,
  input  logic     clr_i,
  input  logic     irq_pend_i,
  input  logic     timed_out_i,
  output logic     en_o,
  output logic     init_o,
  output logic     irq_set_o
);

  logic en_q;
  logic free;
  logic verdict;
  logic set_en, drop_en;
  logic init, irq;

  assign free    = ~irq_pend_i & ~clr_i;
  // closing edge on the selected side of time-out
  assign verdict = cfg_i.late ? timed_out_i : ~timed_out_i;

  always_comb begin
    set_en  = 1'b0;
    drop_en = 1'b1;
    init    = 1'b0;
    irq     = 1'b0;
    if (cfg_i.active) begin
      set_en  = fall_i & free & ~latch_wr_i;
      drop_en = irq_pend_i | latch_wr_i | clr_i | (cfg_i.width & gate_ni);
      if (cfg_i.width) begin
        init = fall_i & free;
        irq  = rise_i & en_q & free & verdict;
      end else begin
        init = fall_i & free & (cfg_i.late | ~en_q | timed_out_i);
        irq  = fall_i & en_q & free & verdict;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (set_en)  en_q <= 1'b1;
    else if (drop_en) en_q <= 1'b0;
  end

  assign en_o      = en_q;
  assign init_o    = init;
  assign irq_set_o = irq;

  assert_en_from_init_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> $past(init));

  assert_width_gate_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.active && cfg_i.width && gate_ni) |=> !en_q);

  assert_pend_drops_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_pend_i |=> !en_q);

  assert_wr_drops_en_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_wr_i |=> !en_q);

  assert_clr_drops_en_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !en_q);

  assert_idle_mode_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.active |=> !en_q);

endmodule

// File: rtl/gate_interval_cmp.sv
module gate_interval_cmp
  import gate_cmp_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic             gate_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] latch_val_i,
  input  logic             latch_wr_i,
  input  logic             clr_i,
  input  logic             irq_pend_i,
  output logic             cnt_en_o,
  output logic             cnt_init_o,
  output logic             irq_set_o,
  output logic             timed_out_o,
  output logic [CNT_W-1:0] count_o
);

  cmp_cfg_t cfg;
  logic     fall, rise;
  logic     en, init, seen;

  assign cfg = decode_mode(mode_i);

  gate_edge_det i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_ni(gate_ni),
    .fall_o (fall),
    .rise_o (rise)
  );

  gate_cmp_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .gate_ni    (gate_ni),
    .fall_i     (fall),
    .rise_i     (rise),
    .latch_wr_i (latch_wr_i),
    .clr_i      (clr_i),
    .irq_pend_i (irq_pend_i),
    .timed_out_i(seen),
    .en_o       (en),
    .init_o     (init),
    .irq_set_o  (irq_set_o)
  );

  gate_down_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (init | clr_i),
    .load_val_i (latch_val_i),
    .en_i       (en),
    .tick_i     (tick_i),
    .count_o    (count_o),
    .timed_out_o(seen)
  );

  assign cnt_en_o    = en;
  assign cnt_init_o  = init;
  assign timed_out_o = seen;

  assert_no_pulse_on_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !(irq_set_o || cnt_init_o));

endmodule

// File: tb/test_gate_interval_cmp.sv
module test_gate_interval_cmp;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   mode = 3'b000;
  logic         gate_n = 1'b1;
  logic         tick = 1'b1;
  logic [W-1:0] latch = '0;
  logic         wr = 1'b0;
  logic         clr = 1'b0;
  logic         pend = 1'b0;
  logic         en_o, init_o, irq_o, to_o;
  logic [W-1:0] cnt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gate_interval_cmp #(.CNT_W(W)) i_gate_interval_cmp (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .gate_ni    (gate_n),
    .tick_i     (tick),
    .latch_val_i(latch),
    .latch_wr_i (wr),
    .clr_i      (clr),
    .irq_pend_i (pend),
    .cnt_en_o   (en_o),
    .cnt_init_o (init_o),
    .irq_set_o  (irq_o),
    .timed_out_o(to_o),
    .count_o    (cnt_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive after falling edge, sample one ns before the rising edge
  task automatic cyc(input logic g, input logic w, input logic p, input logic c);
    @(negedge clk);
    gate_n = g; wr = w; pend = p; clr = c;
    #4;
  endtask

  task automatic preset(input logic [2:0] m, input int n);
    mode = m; latch = W'(n);
    cyc(1, 0, 0, 1);
    cyc(1, 0, 0, 0);
  endtask

  task automatic width_trial(input int n, input int l, input bit late);
    preset({late, 2'b11}, n);
    cyc(0, 0, 0, 0);
    check("R3 init on fall", int'(init_o), 1);
    for (int i = 0; i < l; i++) begin
      cyc(0, 0, 0, 0);
      if (i == 0) check("R3 enable after fall", int'(en_o), 1);
    end
    cyc(1, 0, 0, 0);
    check(late ? "R5 width late pulse" : "R4 width early pulse", int'(irq_o),
          late ? int'(l >= n + 1) : int'(l <= n));
    check("R2 count at close", int'(cnt_o), (n > l) ? n - l : 0);
    check("R2 timeout flag", int'(to_o), int'(l >= n + 1));
    cyc(1, 0, 0, 0);
    check("R6 enable off with gate high", int'(en_o), 0);
  endtask

  task automatic period_trial(input int n, input int p, input bit late);
    int k;
    k = p - 1;
    preset({late, 2'b01}, n);
    cyc(0, 0, 0, 0);
    check(late ? "R8 first fall init" : "R7 first fall init", int'(init_o), 1);
    for (int i = 0; i < k; i++) cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    if (late) begin
      check("R8 period late pulse", int'(irq_o), int'(k >= n + 1));
      check("R8 reinit every fall", int'(init_o), 1);
    end else begin
      check("R7 period early pulse", int'(irq_o), int'(k <= n));
      check("R7 reinit after timeout", int'(init_o), int'(k > n));
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    #3;
    check("R1 en in reset", int'(en_o), 0);
    check("R1 count in reset", int'(cnt_o), 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    mode = 3'b011;
    #4;
    check("R1 en after reset", int'(en_o), 0);
    check("R1 init after reset", int'(init_o), 0);
    check("R1 irq after reset", int'(irq_o), 0);
    check("R1 timeout after reset", int'(to_o), 0);

    for (int late = 0; late < 2; late++)
      for (int n = 0; n < 6; n++)
        for (int l = 0; l < 9; l++) width_trial(n, l, late[0]);

    for (int late = 0; late < 2; late++)
      for (int n = 0; n < 6; n++)
        for (int p = 2; p < 10; p++) period_trial(n, p, late[0]);

    // R2 count holds at zero
    preset(3'b011, 2);
    cyc(0, 0, 0, 0);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 0);
    check("R2 holds at zero", int'(cnt_o), 0);
    check("R2 timeout held", int'(to_o), 1);

    // R9 pending interrupt blocks start and drops enable
    preset(3'b011, 4);
    cyc(0, 0, 1, 0);
    check("R9 no init when pending", int'(init_o), 0);
    cyc(0, 0, 0, 0);
    check("R9 no enable when pending", int'(en_o), 0);
    cyc(1, 0, 0, 0);
    check("R9 no pulse unarmed", int'(irq_o), 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 1, 0);
    check("R9 armed before pend", int'(en_o), 1);
    cyc(0, 0, 0, 0);
    check("R9 enable dropped", int'(en_o), 0);
    cyc(1, 0, 1, 0);
    check("R9 no pulse while pending", int'(irq_o), 0);

    // R10 latch write
    preset(3'b011, 4);
    cyc(0, 1, 0, 0);
    cyc(0, 0, 0, 0);
    check("R10 fall with write leaves disabled", int'(en_o), 0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 1, 0, 0);
    check("R10 armed before write", int'(en_o), 1);
    cyc(0, 0, 0, 0);
    check("R10 write drops enable", int'(en_o), 0);
    cyc(1, 0, 0, 0);
    check("R10 no pulse after write", int'(irq_o), 0);

    // R11 clear during an armed late measurement
    preset(3'b111, 1);
    cyc(0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0);
    latch = 8'd9;
    cyc(1, 0, 0, 1);
    check("R11 no pulse on clear", int'(irq_o), 0);
    check("R11 no init on clear", int'(init_o), 0);
    cyc(1, 0, 0, 0);
    check("R11 enable cleared", int'(en_o), 0);
    check("R11 timeout cleared", int'(to_o), 0);
    check("R11 count preset", int'(cnt_o), 9);

    // R12 compare not selected
    preset(3'b110, 3);
    cyc(0, 0, 0, 0);
    check("R12 no init idle", int'(init_o), 0);
    cyc(0, 0, 0, 0);
    check("R12 no enable idle", int'(en_o), 0);
    cyc(1, 0, 0, 0);
    check("R12 no pulse idle", int'(irq_o), 0);

    done = 1'b1;
    finish_run();
  end

endmodule